// File: doc/BRIEF.md
# General-Purpose I/O Port Slice with Peripheral Direction Override

This block is one 8-bit slice of a general-purpose I/O port, controlled through registers on a small synchronous bus. Three registers are mapped on the bus: an output latch, a read-only view of the pin levels and a per-pin direction mask. Software uses the direction mask to choose which pins the port drives. A timer or PWM peripheral can take over any pin through a per-pin enable. While the peripheral holds a pin, that pin is driven from the peripheral's data and the stored direction bit is left alone.

External pin levels pass through a two-flop synchronizer on the bus clock before anything reads them. The synchronized level goes to three places: the pin-status register, the input-pin bits of the output-latch read, and a capture output for the peripheral. The pin-status register returns the level on every pin, whatever its direction. Software can therefore compare a driven value with the real pin level to detect a short or an overload.

Top module: `gpio_port`

## Requirements
- R1: After reset, the output latch and the direction mask are 0x00. With no peripheral enable active, `pin_oe_o` is 0x00 and `pin_o` is 0x00.
- R2: The direction mask is at offset 0x2. A write there takes effect at the next clock edge, and a read returns the stored value at any time.
- R3: `pin_oe_o[i]` is 1 when direction bit i is 1 (output) or `per_oe_i[i]` is 1. Otherwise it is 0 (input).
- R4: While `per_oe_i[i]` is 1, pin i is driven, and reading offset 0x2 still returns the stored direction bit unchanged.
- R5: `pin_o[i]` equals `per_data_i[i]` while `per_oe_i[i]` is 1. Otherwise it equals output-latch bit i.
- R6: A read of offset 0x1 returns the synchronized pin level for every pin, inputs and outputs alike. That level is the value `pin_i` had two clock edges earlier.
- R7: Offset 0x1 is read-only. A write there changes neither the output latch nor the direction mask.
- R8: The output latch is at offset 0x0 and is written at the next edge. On a read, bit i returns the latch bit when direction bit i is 1, and the synchronized pin level when it is 0.
- R9: `capture_o` always carries the synchronized pin level, two edges behind `pin_i`, whatever the direction or override.
- R10: Offsets 0x3 to 0x7 read as 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Register offset |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| pin_i | input | 8 | External pin levels, asynchronous |
| pin_o | output | 8 | Pin output values |
| pin_oe_o | output | 8 | Pin output enables |
| per_oe_i | input | 8 | Peripheral per-pin override enables |
| per_data_i | input | 8 | Peripheral per-pin output values |
| capture_o | output | 8 | Synchronized pin level for peripheral capture |

## Verification
A corrupted latch or direction bit appears at the ports in the same cycle: `pin_o`, `pin_oe_o` and the offset 0x0/0x2 read data are combinational from the registers. A wrong synchronizer stage becomes visible at `capture_o` and offset 0x1 two edges after the pin changes. An override that leaked into the stored direction bit only shows once the peripheral enable drops: the pin then stays driven, or the readback at offset 0x2 differs. The bench therefore toggles the enables while it writes the direction mask, and compares every output on every cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned OFS_LATCH  = 0;
  localparam int unsigned OFS_STATUS = 1;
  localparam int unsigned OFS_DIR    = 2;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic [1:0] {
    SEL_LATCH,
    SEL_STATUS,
    SEL_DIR,
    SEL_NONE
  } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  import gpio_port_pkg::*;
  localparam int unsigned CW = $clog2(SYNC_DEPTH + 1);

  logic [W-1:0] stage_q [SYNC_DEPTH];

  generate
    for (genvar s = 0; s < SYNC_DEPTH; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= d_i;
      end else begin : g_next
        always_ff @(posedge clk_i or negedge rst_ni)
          if (!rst_ni) stage_q[s] <= '0;
          else         stage_q[s] <= stage_q[s-1];
      end
    end
  endgenerate

  assign q_o = stage_q[SYNC_DEPTH-1];

  // cycles since reset, saturating, so $past never reaches before reset
  logic [CW-1:0] fill_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                        fill_q <= '0;
    else if (fill_q != CW'(SYNC_DEPTH)) fill_q <= fill_q + 1'b1;

  assert_sync_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q == CW'(SYNC_DEPTH)) |-> (q_o == $past(d_i, 2)));
endmodule

// File: rtl/gpio_dir_mux.sv
module gpio_dir_mux #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] latch_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] pin_sync_i,
  input  logic [W-1:0] per_oe_i,
  input  logic [W-1:0] per_data_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe_o,
  output logic [W-1:0] latch_rd_o
);
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      assign pin_oe_o[i]   = dir_i[i] | per_oe_i[i];
      assign pin_o[i]      = per_oe_i[i] ? per_data_i[i] : latch_i[i];
      assign latch_rd_o[i] = dir_i[i] ? latch_i[i] : pin_sync_i[i];
    end
  endgenerate
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [W-1:0]  latch_rd_i,
  input  logic [W-1:0]  pin_sync_i,
  output logic [W-1:0]  rdata_o,
  output logic [W-1:0]  latch_o,
  output logic [W-1:0]  dir_o
);
  import gpio_port_pkg::*;

  reg_sel_e sel;
  always_comb begin
    if      (addr_i == AW'(OFS_LATCH))  sel = SEL_LATCH;
    else if (addr_i == AW'(OFS_STATUS)) sel = SEL_STATUS;
    else if (addr_i == AW'(OFS_DIR))    sel = SEL_DIR;
    else                                sel = SEL_NONE;
  end

  logic [W-1:0] latch_q, dir_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      latch_q <= '0;
      dir_q   <= '0;
    end else if (wr_i) begin
      if (sel == SEL_LATCH) latch_q <= wdata_i;
      if (sel == SEL_DIR)   dir_q   <= wdata_i;
    end

  always_comb begin
    unique case (sel)
      SEL_LATCH:  rdata_o = latch_rd_i;
      SEL_STATUS: rdata_o = pin_sync_i;
      SEL_DIR:    rdata_o = dir_q;
      default:    rdata_o = '0;
    endcase
  end

  assign latch_o = latch_q;
  assign dir_o   = dir_q;

  assert_dir_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(OFS_DIR)) |=> (dir_q == $past(wdata_i)));
  assert_dir_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == AW'(OFS_DIR)) |=> $stable(dir_q));
  assert_status_ro_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == AW'(OFS_STATUS)) |=> ($stable(latch_q) && $stable(dir_q)));
  assert_unmapped_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i > AW'(OFS_DIR)) |-> (rdata_o == '0));
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int unsigned W  = 8,
  parameter int unsigned AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          wr_i,
  input  logic [W-1:0]  wdata_i,
  output logic [W-1:0]  rdata_o,
  input  logic [W-1:0]  pin_i,
  output logic [W-1:0]  pin_o,
  output logic [W-1:0]  pin_oe_o,
  input  logic [W-1:0]  per_oe_i,
  input  logic [W-1:0]  per_data_i,
  output logic [W-1:0]  capture_o
);
  logic [W-1:0] pin_sync, latch, dir, latch_rd;

  gpio_sync #(.W(W)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_sync)
  );

  gpio_regfile #(.W(W), .AW(AW)) i_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (addr_i),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .latch_rd_i(latch_rd),
    .pin_sync_i(pin_sync),
    .rdata_o   (rdata_o),
    .latch_o   (latch),
    .dir_o     (dir)
  );

  gpio_dir_mux #(.W(W)) i_mux (
    .latch_i   (latch),
    .dir_i     (dir),
    .pin_sync_i(pin_sync),
    .per_oe_i  (per_oe_i),
    .per_data_i(per_data_i),
    .pin_o     (pin_o),
    .pin_oe_o  (pin_oe_o),
    .latch_rd_o(latch_rd)
  );

  assign capture_o = pin_sync;

  // with the override released, driving follows the stored direction (R3)
  assert_release_follows_dir_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (per_oe_i == '0) |-> (pin_oe_o == dir));
endmodule

// File: tb/test_gpio_port.sv
`timescale 1ns/1ps
module test_gpio_port;
  localparam int W  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr = 1'b0;
  logic [W-1:0]  wdata = '0, pin = '0, per_oe = '0, per_data = '0;
  logic [W-1:0]  rdata, pin_o, pin_oe, capture;

  always #2.5 clk = ~clk;

  gpio_port #(.W(W), .AW(AW)) i_gpio_port (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_i(wr), .wdata_i(wdata),
    .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o), .pin_oe_o(pin_oe),
    .per_oe_i(per_oe), .per_data_i(per_data), .capture_o(capture)
  );

  int checks = 0, fails = 0;
  bit finished = 0;

  // behavioural reference
  logic [W-1:0] m_latch, m_dir;
  logic [W-1:0] m_pipe[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_latch = '0; m_dir = '0;
      m_pipe = '{8'h00, 8'h00};
    end else begin
      if (wr && addr == 0) m_latch = wdata;
      if (wr && addr == 2) m_dir   = wdata;
      m_pipe.push_back(pin);
      void'(m_pipe.pop_front());
    end
  end

  function automatic logic [W-1:0] m_sync();
    return m_pipe[0];
  endfunction

  function automatic logic [W-1:0] m_read(input logic [AW-1:0] a);
    case (a)
      0: return (m_dir & m_latch) | (~m_dir & m_sync());
      1: return m_sync();
      2: return m_dir;
      default: return '0;
    endcase
  endfunction

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) if (!finished && m_pipe.size() == 2) begin
    check("R3", pin_oe, m_dir | per_oe);
    check("R5", pin_o, (per_oe & per_data) | (~per_oe & m_latch));
    check("R9", capture, m_sync());
    case (addr)
      0: check("R8", rdata, m_read(addr));
      1: check("R6", rdata, m_read(addr));
      2: check("R2", rdata, m_read(addr));
      default: check("R10", rdata, m_read(addr));
    endcase
  end

  task automatic drive(input logic [AW-1:0] a, input logic w, input logic [W-1:0] d);
    @(posedge clk); #1;
    addr = a; wr = w; wdata = d;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(addr, 1'b0, '0);
  endtask

  initial begin
    #5000000;
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 oe", pin_oe, 8'h00);
    check("R1 out", pin_o, 8'h00);
    @(posedge clk); #1 rst_n = 1'b1;
    drive(2, 1'b0, '0); @(negedge clk);
    check("R1 dir", rdata, 8'h00);

    // direction and latch
    drive(2, 1'b1, 8'hA5);
    drive(2, 1'b0, '0); @(negedge clk);
    check("R2 readback", rdata, 8'hA5);
    drive(0, 1'b1, 8'h3C);
    pin = 8'h5A;
    idle(3);
    drive(0, 1'b0, '0); @(negedge clk);
    check("R8 mixed", rdata, (8'hA5 & 8'h3C) | (~8'hA5 & 8'h5A));
    drive(1, 1'b0, '0); @(negedge clk);
    check("R6 status", rdata, 8'h5A);

    // override keeps stored direction
    drive(2, 1'b1, 8'h0F);
    per_oe = 8'hF0; per_data = 8'h90;
    drive(2, 1'b0, '0); @(negedge clk);
    check("R4 dir kept", rdata, 8'h0F);
    check("R4 forced", pin_oe, 8'hFF);
    check("R5 per data", pin_o, 8'h9C);
    per_oe = 8'h00;
    drive(2, 1'b0, '0); @(negedge clk);
    check("R3 release", pin_oe, 8'h0F);

    // read-only status
    drive(1, 1'b1, 8'hFF);
    drive(2, 1'b0, '0); @(negedge clk);
    check("R7 dir", rdata, 8'h0F);
    drive(0, 1'b0, '0); @(negedge clk);
    check("R7 latch", pin_o, 8'h3C);

    // unmapped
    drive(5, 1'b1, 8'hFF);
    drive(7, 1'b1, 8'h77);
    drive(2, 1'b0, '0); @(negedge clk);
    check("R10 dir", rdata, 8'h0F);
    check("R10 latch", pin_o, 8'h3C);
    for (int a = 3; a < 8; a++) begin
      drive(AW'(a), 1'b0, '0); @(negedge clk);
      check("R10 read", rdata, 8'h00);
    end

    // random traffic, checked every cycle
    for (int k = 0; k < 2000; k++) begin
      @(posedge clk); #1;
      addr = AW'($urandom_range(0, 7));
      wr = ($urandom_range(0, 3) == 0);
      wdata = 8'($urandom);
      pin = 8'($urandom);
      per_oe = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
      per_data = 8'($urandom);
    end
    idle(4);
    @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule